// File: doc/BRIEF.md
# NAND Identification and Status Byte Responder

This block produces the byte that a NAND flash device places on its data bus when the host asks for the device identity or for its status. A host-side command decoder feeds it command strobes with an eight-bit code, address strobes and read strobes. The block also receives the live write-protect pin, an array-busy level and a fail pulse from the program/erase engine. Configuration straps give the manufacturer code, the device code, the bus width and whether the part uses large pages.

A small state machine tracks what the next read returns. The states are `ST_IDLE`, `ST_ID_ARM` (identify command seen, waiting for its address byte), `ST_ID_SEND` (identity bytes being read out), `ST_ID_END` (all identity bytes consumed) and `ST_STAT` (status being returned).

The transitions are as follows:
- Any command code moves the machine: 0x90 goes to `ST_ID_ARM`, 0x70 goes to `ST_STAT`, and every other code goes to `ST_IDLE`.
- An address strobe in `ST_ID_ARM` goes to `ST_ID_SEND` at index 0.
- A read strobe in `ST_ID_SEND` advances the index, and after the last byte it goes to `ST_ID_END`.

All other strobes leave the state unchanged. The status register keeps the error and per-plane fail flags. The ready bit and the write-protect bit are taken live from their inputs.

Top module: `nand_idstat_resp`

## Requirements
- R1: After reset the output is 0x0000, the machine is in `ST_IDLE` and the error and plane flags are clear.
- R2: The status byte is bit 0 error, bits 4..1 plane fail flags (plane 0 in bit 1), bit 5 zero, bit 6 ready (the inverse of `busy_i`), and bit 7 equal to the current `wp_n_i` level. Bits 6 and 7 follow their pins in the same cycle.
- R3: The identity sequence starts only after command 0x90 followed by one address strobe. Until that address byte arrives, the output is 0x00.
- R4: Identity bytes appear in this order: manufacturer code, device code, don't-care byte 0xA5, geometry byte. Each read strobe advances to the next byte one cycle later.
- R5: The geometry byte is 0x15 for large-page on an 8-bit bus, 0x55 for large-page on a 16-bit bus, and 0xC0 for small-page regardless of width.
- R6: Every bit of `data_o` above bit 7 is always zero.
- R7: In `ST_STAT`, every read strobe returns the status again, without advancing, until a new command is accepted.
- R8: After the fourth identity byte has been read, the output is 0x00 until a new command arrives. Further address strobes are ignored.
- R9: A pulse on `op_fail_i` sets the error bit and ORs `plane_fail_i` into the plane flags. Commands 0x80 (program), 0x60 (erase) and 0xFF (reset) clear these flags. When a fail pulse and a clearing command occur in the same cycle, the flags end up set.
- R10: Any command code other than 0x90 or 0x70 gives output 0x00. A command strobe takes priority over an address strobe in the same cycle, and an address strobe takes priority over a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_code_i | input | 8 | Command code |
| addr_valid_i | input | 1 | Address byte strobe |
| rd_strobe_i | input | 1 | Read strobe, consumes the current byte |
| wp_n_i | input | 1 | Write-protect pin level, high = writes allowed |
| busy_i | input | 1 | Array busy level |
| op_fail_i | input | 1 | Program/erase failure pulse |
| plane_fail_i | input | NPLANES | Per-plane failure flags sampled with `op_fail_i` |
| manf_code_i | input | 8 | Manufacturer code strap |
| dev_code_i | input | 8 | Device code strap |
| bus16_i | input | 1 | Strap, 1 = 16-bit bus |
| large_page_i | input | 1 | Strap, 1 = large-page part |
| data_o | output | DATA_W | Byte for the next read, zero-extended |

## Verification
The bench checks several corner cases:
- **Read before the address byte.** A read strobe issued before the identify address byte must return zero. A design that starts the sequence on the command alone would return the manufacturer code here.
- **Extra strobes after the sequence.** Reads and address strobes arriving after the geometry byte must keep the output at zero. A design that wraps its index or restarts on the address would present identity bytes again.
- **Status reads and live pins.** Repeated status reads must not drift. The write-protect and busy pins are toggled during status, so a design that latches them at command time would show stale bits.
- **Flag clearing and priority.** A fail pulse is issued in the same cycle as a clearing command, and simultaneous command, address and read strobes are applied. These expose a wrong set/clear priority or a wrong strobe priority.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID_ARM,
        ST_ID_SEND,
        ST_ID_END,
        ST_STAT
    } resp_state_e;

    localparam logic [7:0] CODE_IDENT   = 8'h90;
    localparam logic [7:0] CODE_STATUS  = 8'h70;
    localparam logic [7:0] CODE_RESET   = 8'hFF;
    localparam logic [7:0] CODE_PROGRAM = 8'h80;
    localparam logic [7:0] CODE_ERASE   = 8'h60;

    localparam logic [7:0] GEO_LP_X8  = 8'h15;
    localparam logic [7:0] GEO_LP_X16 = 8'h55;
    localparam logic [7:0] GEO_SP     = 8'hC0;

    function automatic logic [7:0] geometry_byte(input logic large_page, input logic bus16);
        if (!large_page)
            return GEO_SP;
        return bus16 ? GEO_LP_X16 : GEO_LP_X8;
    endfunction

    function automatic logic clears_flags(input logic [7:0] code);
        return (code == CODE_PROGRAM) || (code == CODE_ERASE) || (code == CODE_RESET);
    endfunction

endpackage

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
    import nand_resp_pkg::*;
#(
    parameter int ID_LEN = 4,
    localparam int IDX_W = (ID_LEN > 1) ? $clog2(ID_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic [7:0]       cmd_code_i,
    input  logic             addr_valid_i,
    input  logic             rd_strobe_i,
    output resp_state_e      state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             clr_flags_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_LEN - 1);

    resp_state_e      st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    always_comb begin
        st_d        = st_q;
        idx_d       = idx_q;
        clr_flags_o = 1'b0;
        if (cmd_valid_i) begin
            idx_d       = '0;
            clr_flags_o = clears_flags(cmd_code_i);
            if (cmd_code_i == CODE_IDENT)
                st_d = ST_ID_ARM;
            else if (cmd_code_i == CODE_STATUS)
                st_d = ST_STAT;
            else
                st_d = ST_IDLE;
        end else if (addr_valid_i) begin
            unique case (st_q)
                ST_ID_ARM: begin
                    st_d  = ST_ID_SEND;
                    idx_d = '0;
                end
                ST_IDLE, ST_ID_SEND, ST_ID_END, ST_STAT: ;
                default: st_d = ST_IDLE;
            endcase
        end else if (rd_strobe_i) begin
            unique case (st_q)
                ST_ID_SEND: begin
                    if (idx_q == LAST_IDX)
                        st_d = ST_ID_END;
                    else
                        idx_d = idx_q + 1'b1;
                end
                ST_IDLE, ST_ID_ARM, ST_ID_END, ST_STAT: ;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    assign state_o = st_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/nand_status_reg.sv
module nand_status_reg #(
    parameter int NPLANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               fail_i,
    input  logic [NPLANES-1:0] plane_fail_i,
    input  logic               busy_i,
    input  logic               wp_n_i,
    output logic [7:0]         status_o
);

    logic               err_q;
    logic [NPLANES-1:0] plane_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            plane_q <= '0;
        end else if (fail_i) begin
            err_q   <= 1'b1;
            plane_q <= (clr_i ? '0 : plane_q) | plane_fail_i;
        end else if (clr_i) begin
            err_q   <= 1'b0;
            plane_q <= '0;
        end
    end

    logic [3:0] plane_bits;

    for (genvar p = 0; p < 4; p++) begin : g_plane
        if (p < NPLANES) begin : g_used
            assign plane_bits[p] = plane_q[p];
        end else begin : g_unused
            assign plane_bits[p] = 1'b0;
        end
    end

    assign status_o = {wp_n_i, ~busy_i, 1'b0, plane_bits, err_q};

endmodule

// File: rtl/nand_id_bytes.sv
module nand_id_bytes
    import nand_resp_pkg::*;
#(
    parameter int         ID_LEN   = 4,
    parameter logic [7:0] FILLER   = 8'hA5,
    localparam int        IDX_W    = (ID_LEN > 1) ? $clog2(ID_LEN) : 1
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       manf_i,
    input  logic [7:0]       dev_i,
    input  logic             large_page_i,
    input  logic             bus16_i,
    output logic [7:0]       byte_o
);

    always_comb begin
        unique case (idx_i)
            IDX_W'(0): byte_o = manf_i;
            IDX_W'(1): byte_o = dev_i;
            IDX_W'(3): byte_o = geometry_byte(large_page_i, bus16_i);
            default:   byte_o = FILLER;
        endcase
    end

endmodule

// File: rtl/nand_idstat_resp.sv
module nand_idstat_resp
    import nand_resp_pkg::*;
#(
    parameter int         DATA_W  = 16,
    parameter int         NPLANES = 4,
    parameter int         ID_LEN  = 4,
    parameter logic [7:0] FILLER  = 8'hA5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid_i,
    input  logic [7:0]         cmd_code_i,
    input  logic               addr_valid_i,
    input  logic               rd_strobe_i,
    input  logic               wp_n_i,
    input  logic               busy_i,
    input  logic               op_fail_i,
    input  logic [NPLANES-1:0] plane_fail_i,
    input  logic [7:0]         manf_code_i,
    input  logic [7:0]         dev_code_i,
    input  logic               bus16_i,
    input  logic               large_page_i,
    output logic [DATA_W-1:0]  data_o
);

    localparam int IDX_W = (ID_LEN > 1) ? $clog2(ID_LEN) : 1;

    resp_state_e      state;
    logic [IDX_W-1:0] idx;
    logic             clr_flags;
    logic [7:0]       status_byte;
    logic [7:0]       id_byte;
    logic [7:0]       out_byte;

    nand_cmd_fsm #(.ID_LEN(ID_LEN)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_code_i   (cmd_code_i),
        .addr_valid_i (addr_valid_i),
        .rd_strobe_i  (rd_strobe_i),
        .state_o      (state),
        .idx_o        (idx),
        .clr_flags_o  (clr_flags)
    );

    nand_status_reg #(.NPLANES(NPLANES)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr_flags),
        .fail_i       (op_fail_i),
        .plane_fail_i (plane_fail_i),
        .busy_i       (busy_i),
        .wp_n_i       (wp_n_i),
        .status_o     (status_byte)
    );

    nand_id_bytes #(.ID_LEN(ID_LEN), .FILLER(FILLER)) u_id (
        .idx_i        (idx),
        .manf_i       (manf_code_i),
        .dev_i        (dev_code_i),
        .large_page_i (large_page_i),
        .bus16_i      (bus16_i),
        .byte_o       (id_byte)
    );

    always_comb begin
        unique case (state)
            ST_ID_SEND: out_byte = id_byte;
            ST_STAT:    out_byte = status_byte;
            ST_IDLE, ST_ID_ARM, ST_ID_END: out_byte = 8'h00;
            default:    out_byte = 8'h00;
        endcase
    end

    assign data_o = DATA_W'(out_byte);

endmodule

// File: rtl/nand_resp_chk.sv
module nand_resp_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid_i,
    input logic [7:0]        cmd_code_i,
    input logic              addr_valid_i,
    input logic              rd_strobe_i,
    input logic              wp_n_i,
    input logic              busy_i,
    input logic              op_fail_i,
    input logic [7:0]        manf_code_i,
    input logic [DATA_W-1:0] data_o
);

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o >> 8) == '0);

    a_r3_wait_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 8'h90) |=> data_o[7:0] == 8'h00);

    a_r3_first_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 8'h90) ##1 (!cmd_valid_i && addr_valid_i)
        |=> data_o[7:0] == manf_code_i);

    a_r2_live_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 8'h70) |=> (data_o[7] == wp_n_i) && (data_o[6] == !busy_i));

    a_r9_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 8'h80 && !op_fail_i) ##1
        (cmd_valid_i && cmd_code_i == 8'h70 && !op_fail_i) |=> data_o[4:0] == 5'd0);

    a_r10_other_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 8'h00) |=> data_o == '0);

endmodule

bind nand_idstat_resp nand_resp_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_code_i   (cmd_code_i),
    .addr_valid_i (addr_valid_i),
    .rd_strobe_i  (rd_strobe_i),
    .wp_n_i       (wp_n_i),
    .busy_i       (busy_i),
    .op_fail_i    (op_fail_i),
    .manf_code_i  (manf_code_i),
    .data_o       (data_o)
);

// File: tb/tb_nand_idstat_resp.sv
module tb_nand_idstat_resp;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int NPLANES    = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic [7:0]         cmd_code = 8'h00;
    logic               addr_valid = 1'b0;
    logic               rd_strobe = 1'b0;
    logic               wp_n = 1'b1;
    logic               busy = 1'b0;
    logic               op_fail = 1'b0;
    logic [NPLANES-1:0] plane_fail = '0;
    logic [7:0]         manf = 8'hEC;
    logic [7:0]         dev = 8'hDA;
    logic               bus16 = 1'b0;
    logic               lp = 1'b1;
    logic [DATA_W-1:0]  data_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_idstat_resp #(.DATA_W(DATA_W), .NPLANES(NPLANES)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid),
        .cmd_code_i   (cmd_code),
        .addr_valid_i (addr_valid),
        .rd_strobe_i  (rd_strobe),
        .wp_n_i       (wp_n),
        .busy_i       (busy),
        .op_fail_i    (op_fail),
        .plane_fail_i (plane_fail),
        .manf_code_i  (manf),
        .dev_code_i   (dev),
        .bus16_i      (bus16),
        .large_page_i (lp),
        .data_o       (data_o)
    );

    // Behavioural reference: mode 0 idle, 1 waiting for address, 2 sending, 3 done, 4 status
    int       m_mode = 0;
    int       m_idx  = 0;
    bit       m_err  = 0;
    bit [3:0] m_pl   = '0;

    function automatic logic [15:0] model_out();
        logic [7:0] b;
        b = 8'h00;
        if (m_mode == 2) begin
            if (m_idx == 0) b = manf;
            else if (m_idx == 1) b = dev;
            else if (m_idx == 2) b = 8'hA5;
            else b = !lp ? 8'hC0 : (bus16 ? 8'h55 : 8'h15);
        end else if (m_mode == 4) begin
            b = {wp_n, !busy, 1'b0, m_pl, m_err};
        end
        return {8'h00, b};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_idx = 0; m_err = 0; m_pl = '0;
        end else begin
            bit clr;
            clr = cmd_valid && (cmd_code == 8'h80 || cmd_code == 8'h60 || cmd_code == 8'hFF);
            if (clr) begin m_err = 0; m_pl = '0; end
            if (op_fail) begin m_err = 1; m_pl = m_pl | plane_fail; end
            if (cmd_valid) begin
                m_idx  = 0;
                m_mode = (cmd_code == 8'h90) ? 1 : (cmd_code == 8'h70) ? 4 : 0;
            end else if (addr_valid) begin
                if (m_mode == 1) begin m_mode = 2; m_idx = 0; end
            end else if (rd_strobe) begin
                if (m_mode == 2) begin
                    if (m_idx == 3) m_mode = 3;
                    else m_idx = m_idx + 1;
                end
            end
        end
    end

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            logic [15:0] e;
            string tag;
            e = model_out();
            case (m_mode)
                1: tag = "R3";
                2: tag = "R4";
                3: tag = "R8";
                4: tag = "R7";
                default: tag = "R10";
            endcase
            if (data_o[15:8] != 8'h00) tag = "R6";
            n_checks++;
            if (data_o !== e) begin
                n_fail++;
                $display("FAIL %s per-cycle: actual %h expected %h", tag, data_o, e);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] exp);
        #1;
        n_checks++;
        if (data_o !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, data_o, exp);
        end
    endtask

    task automatic strobe(input bit cv, input logic [7:0] code, input bit av, input bit rd);
        @(negedge clk);
        cmd_valid = cv; cmd_code = code; addr_valid = av; rd_strobe = rd;
        @(negedge clk);
        cmd_valid = 0; addr_valid = 0; rd_strobe = 0;
    endtask

    task automatic fail_pulse(input logic [3:0] pf);
        @(negedge clk);
        op_fail = 1; plane_fail = pf;
        @(negedge clk);
        op_fail = 0; plane_fail = '0;
    endtask

    task automatic ident_run(input logic [7:0] geo, input string geo_tag);
        strobe(1, 8'h90, 0, 0);
        chk("R3", 16'h0000);
        strobe(0, 8'h00, 0, 1);
        chk("R3", 16'h0000);
        strobe(0, 8'h00, 1, 0);
        chk("R4", {8'h00, manf});
        strobe(0, 8'h00, 0, 1);
        chk("R4", {8'h00, dev});
        strobe(0, 8'h00, 0, 1);
        chk("R4", 16'h00A5);
        strobe(0, 8'h00, 0, 1);
        chk(geo_tag, {8'h00, geo});
        strobe(0, 8'h00, 0, 1);
        chk("R8", 16'h0000);
        strobe(0, 8'h00, 1, 0);
        chk("R8", 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 16'h0000);
        rst_n = 1;
        @(negedge clk);
        chk("R1", 16'h0000);

        // identity: large page, 8-bit
        ident_run(8'h15, "R5");
        // large page, 16-bit
        bus16 = 1; manf = 8'h2C; dev = 8'hCA;
        ident_run(8'h55, "R5");
        // small page
        lp = 0; bus16 = 0; manf = 8'h98; dev = 8'h73;
        ident_run(8'hC0, "R5");

        // status with live pins
        wp_n = 1; busy = 0;
        strobe(1, 8'h70, 0, 0);
        chk("R2", 16'h00C0);
        @(negedge clk); wp_n = 0;
        chk("R2", 16'h0040);
        @(negedge clk); busy = 1;
        chk("R2", 16'h0000);
        @(negedge clk); wp_n = 1; busy = 0;
        for (int i = 0; i < 3; i++) begin
            strobe(0, 8'h00, 0, 1);
            chk("R7", 16'h00C0);
        end
        strobe(0, 8'h00, 1, 0);
        chk("R7", 16'h00C0);

        // failure flags
        fail_pulse(4'b0101);
        chk("R9", 16'h00CB);
        strobe(1, 8'h80, 0, 0);
        strobe(1, 8'h70, 0, 0);
        chk("R9", 16'h00C0);
        fail_pulse(4'b1000);
        chk("R9", 16'h00D1);
        strobe(1, 8'h60, 0, 0);
        strobe(1, 8'h70, 0, 0);
        chk("R9", 16'h00C0);
        fail_pulse(4'b0010);
        strobe(1, 8'hFF, 0, 0);
        chk("R10", 16'h0000);
        strobe(1, 8'h70, 0, 0);
        chk("R9", 16'h00C0);
        // fail together with a clearing command: set wins
        @(negedge clk);
        cmd_valid = 1; cmd_code = 8'h80; op_fail = 1; plane_fail = 4'b0001;
        @(negedge clk);
        cmd_valid = 0; op_fail = 0; plane_fail = '0;
        strobe(1, 8'h70, 0, 0);
        chk("R9", 16'h00C3);

        // other codes and strobe priority
        strobe(1, 8'h00, 0, 0);
        chk("R10", 16'h0000);
        strobe(1, 8'h90, 0, 0);
        strobe(1, 8'h70, 1, 0);
        chk("R10", 16'h00C3);
        lp = 1; bus16 = 0; manf = 8'h01; dev = 8'hF1;
        strobe(1, 8'h90, 0, 0);
        strobe(0, 8'h00, 1, 1);
        chk("R10", 16'h0001);
        strobe(1, 8'h35, 0, 0);
        chk("R10", 16'h0000);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule